// File: doc/BRIEF.md
# Eventual Sequence Obligation Monitor

This monitor watches a design for a liveness rule: every time the trigger input pulses, a fixed run of step conditions must appear on consecutive clock cycles at some later point, before the end-of-execution input is raised. The default run has three steps, for example "b, then c, then d". If end of execution arrives while an obligation has not yet been met, the monitor raises its failure flag in that same cycle.

The block has two parts. The first is a one-bit pending flag that the trigger sets. It holds itself through a self-loop for as long as no complete run has been seen. The second is a small detector that follows partial progress through the run, one register per step already matched. A trigger clears all detector progress, so each trigger starts a fresh and complete obligation. The obligation status is the pending register itself; no other state is kept. All inputs are plain control levels sampled on the rising clock edge. There is no data stream, so no valid/ready handshake is used. The failure output is combinational from the end-of-execution input and the current pending state.

Top module: `eventually_obligation_monitor`

## Requirements
- R1: After reset nothing is pending and the detector holds no progress. An end-of-execution pulse with no earlier trigger leaves `fail_o` low.
- R2: A trigger opens an obligation. Raising `eoe_i` in any later cycle before the run completes drives `fail_o` high in that cycle.
- R3: The run is met when `step_i[0]`, `step_i[1]`, …, `step_i[SEQ_LEN-1]` are high on SEQ_LEN consecutive cycles, in that bit order, with the first step no earlier than the cycle after the trigger. An `eoe_i` in the cycle of the last step, or later, gives no failure. The step inputs may overlap, for example all high at once.
- R4: Meeting the run clears the pending state. Later `eoe_i` pulses leave `fail_o` low until the next trigger.
- R5: `fail_o` is high only in a cycle where `eoe_i` is high. In cycles with an open obligation and `eoe_i` low, it stays low.
- R6: A trigger that arrives while an obligation is pending keeps it pending and throws away partial progress. A run that started before the new trigger does not discharge it, and a full run after it does.
- R7: A trigger in the cycle of the last step opens a new obligation that this run does not meet. A trigger in the same cycle as `eoe_i` gives a failure in that cycle.
- R8: A run with a gap between steps does not discharge the obligation.
- R9: A first step that is high in the trigger cycle itself does not count toward the run.
- R10: `eoe_i` does not clear the pending state. If the run never occurs, every `eoe_i` pulse after the trigger fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger that opens a new obligation |
| step_i | input | SEQ_LEN | Step conditions; bit 0 is the first step of the run |
| eoe_i | input | 1 | End of execution |
| fail_o | output | 1 | Obligation unmet at end of execution |

## Verification
The bench builds the monitor with SEQ_LEN = 3, so bit 0, bit 1 and bit 2 of `step_i` stand for the three steps. This length is enough to reach the cases where partial progress sits in the middle register: a trigger between the second and third step, a gap after the first step, and all three steps overlapping. It also reaches the case where the last step and a new trigger fall in the same cycle.

// File: rtl/obligation_mon_pkg.sv
package obligation_mon_pkg;
  localparam int unsigned SEQ_LEN_DEFAULT = 3;
  localparam int unsigned SEQ_LEN_MIN     = 1;
endpackage

// File: rtl/obligation_seq_detector.sv
module obligation_seq_detector #(
  parameter int unsigned SEQ_LEN = obligation_mon_pkg::SEQ_LEN_DEFAULT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic               flush_i,
  input  logic [SEQ_LEN-1:0] step_i,
  output logic               hit_o
);
  localparam int unsigned LAST = SEQ_LEN - 1;

  generate
    if (SEQ_LEN == 1) begin : g_single
      assign hit_o = arm_i & step_i[0] & ~flush_i;
    end else begin : g_chain
      localparam int unsigned PROG_W = SEQ_LEN - 1;
      logic [PROG_W-1:0] prog_q;
      logic [PROG_W-1:0] prog_d;

      always_comb begin
        prog_d[0] = arm_i & step_i[0] & ~flush_i;
        for (int k = 1; k < PROG_W; k++) begin
          prog_d[k] = prog_q[k-1] & step_i[k] & ~flush_i;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prog_q <= '0;
        else         prog_q <= prog_d;
      end

      assign hit_o = prog_q[PROG_W-1] & step_i[LAST] & ~flush_i;

      // A trigger leaves no progress behind, so no completion the next cycle (R6)
      assert_flush_blocks_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !hit_o);
    end
  endgenerate
endmodule

// File: rtl/obligation_pending_flag.sv
module obligation_pending_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clear_i,
  output logic open_o,
  output logic held_o
);
  logic held_q;

  assign open_o = set_i | (held_q & ~clear_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= open_o;
  end

  assign held_o = held_q;

  assert_trigger_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> held_o);

  assert_pending_self_loop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && !clear_i) |=> held_o);
endmodule

// File: rtl/eventually_obligation_monitor.sv
module eventually_obligation_monitor #(
  parameter int unsigned SEQ_LEN = obligation_mon_pkg::SEQ_LEN_DEFAULT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic [SEQ_LEN-1:0] step_i,
  input  logic               eoe_i,
  output logic               fail_o
);
  logic seq_hit;
  logic pend_open;
  logic pend_held;

  initial begin
    assert_len_valid_R3: assert (SEQ_LEN >= obligation_mon_pkg::SEQ_LEN_MIN)
      else $error("SEQ_LEN must be at least one");
  end

  obligation_seq_detector #(.SEQ_LEN(SEQ_LEN)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (pend_held),
    .flush_i (trig_i),
    .step_i  (step_i),
    .hit_o   (seq_hit)
  );

  obligation_pending_flag u_pending (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (trig_i),
    .clear_i (seq_hit),
    .open_o  (pend_open),
    .held_o  (pend_held)
  );

  assign fail_o = eoe_i & pend_open;

  assert_hit_discharges_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_hit |=> !pend_held);

  assert_fail_needs_eoe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> eoe_i);

  assert_idle_no_fail_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_held && !trig_i) |-> !fail_o);

  assert_trigger_eoe_fails_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && eoe_i) |-> fail_o);
endmodule

// File: tb/eventually_obligation_monitor_test.sv
module eventually_obligation_monitor_test;
  localparam int unsigned N = 3;
  localparam logic [N-1:0] SB = 3'b001;
  localparam logic [N-1:0] SC = 3'b010;
  localparam logic [N-1:0] SD = 3'b100;
  localparam logic [N-1:0] SZ = 3'b000;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         trig = 1'b0;
  logic [N-1:0] steps = '0;
  logic         eoe = 1'b0;
  logic         fail;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  item_t sb_q[$];

  always #2 clk = ~clk;

  eventually_obligation_monitor #(.SEQ_LEN(N)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .trig_i (trig),
    .step_i (steps),
    .eoe_i  (eoe),
    .fail_o (fail)
  );

  task automatic drive(input logic t, input logic [N-1:0] s, input logic e,
                       input logic exp, input string req);
    item_t it;
    @(negedge clk);
    trig = t; steps = s; eoe = e;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) drive(1'b0, SZ, 1'b0, 1'b0, req);
  endtask

  task automatic discharge(input string req);
    drive(1'b0, SB, 1'b0, 1'b0, req);
    drive(1'b0, SC, 1'b0, 1'b0, req);
    drive(1'b0, SD, 1'b0, 1'b0, req);
    drive(1'b0, SZ, 1'b1, 1'b0, req);
  endtask

  // Monitor: compares fail_o against the scoreboard after the inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (fail !== it.exp) begin
          n_fail++;
          $display("FAIL %s: fail_o=%b expected=%b at %0t", it.req, fail, it.exp, $time);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state, eoe during and after reset gives no failure
    eoe = 1'b1;
    #1;
    n_checks++;
    if (fail !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: fail_o=%b expected=0 in reset", fail);
    end
    eoe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, SZ, 1'b1, 1'b0, "R1");
    drive(1'b0, SD, 1'b0, 1'b0, "R1");

    // R2, R5: trigger then eoe without run
    drive(1'b1, SZ, 1'b0, 1'b0, "R2");
    idle(3, "R5");
    drive(1'b0, SZ, 1'b1, 1'b1, "R2");
    // R10: eoe does not clear pending
    drive(1'b0, SZ, 1'b0, 1'b0, "R10");
    drive(1'b0, SZ, 1'b1, 1'b1, "R10");

    // R3: complete run, eoe at the last step
    drive(1'b0, SB, 1'b0, 1'b0, "R3");
    drive(1'b0, SC, 1'b0, 1'b0, "R3");
    drive(1'b0, SD, 1'b1, 1'b0, "R3");
    // R4: discharged stays clear
    drive(1'b0, SZ, 1'b1, 1'b0, "R4");
    idle(2, "R4");
    drive(1'b0, SZ, 1'b1, 1'b0, "R4");

    // R3: overlapping steps all high
    drive(1'b1, SZ, 1'b0, 1'b0, "R3");
    drive(1'b0, 3'b111, 1'b0, 1'b0, "R3");
    drive(1'b0, 3'b111, 1'b0, 1'b0, "R3");
    drive(1'b0, 3'b111, 1'b1, 1'b0, "R3");

    // R8: gap in the run
    drive(1'b1, SZ, 1'b0, 1'b0, "R8");
    drive(1'b0, SB, 1'b0, 1'b0, "R8");
    drive(1'b0, SZ, 1'b0, 1'b0, "R8");
    drive(1'b0, SC, 1'b0, 1'b0, "R8");
    drive(1'b0, SD, 1'b0, 1'b0, "R8");
    drive(1'b0, SZ, 1'b1, 1'b1, "R8");
    discharge("R8");

    // R9: first step in the trigger cycle does not count
    drive(1'b1, SB, 1'b0, 1'b0, "R9");
    drive(1'b0, SC, 1'b0, 1'b0, "R9");
    drive(1'b0, SD, 1'b0, 1'b0, "R9");
    drive(1'b0, SZ, 1'b1, 1'b1, "R9");
    discharge("R9");

    // R6: re-trigger mid-run restarts detection
    drive(1'b1, SZ, 1'b0, 1'b0, "R6");
    drive(1'b0, SB, 1'b0, 1'b0, "R6");
    drive(1'b0, SC, 1'b0, 1'b0, "R6");
    drive(1'b1, SZ, 1'b0, 1'b0, "R6");
    drive(1'b0, SD, 1'b0, 1'b0, "R6");
    drive(1'b0, SZ, 1'b1, 1'b1, "R6");
    discharge("R6");

    // R7: trigger on the last step opens a new obligation
    drive(1'b1, SZ, 1'b0, 1'b0, "R7");
    drive(1'b0, SB, 1'b0, 1'b0, "R7");
    drive(1'b0, SC, 1'b0, 1'b0, "R7");
    drive(1'b1, SD, 1'b0, 1'b0, "R7");
    drive(1'b0, SZ, 1'b1, 1'b1, "R7");
    discharge("R7");
    // R7: trigger with eoe in the same cycle from idle
    drive(1'b1, SZ, 1'b1, 1'b1, "R7");
    discharge("R7");

    drive(1'b0, SZ, 1'b0, 1'b0, "R5");
    @(negedge clk);
    #2;
    finish_run();
  end
endmodule